// File: doc/BRIEF.md
# Register-Indirect Memory Sequencer

This block carries out one memory operation at a time. Every operation finds its memory address indirectly. The address is the full content of a register named by a 5-bit index, and nothing is added to it. A register file, an address register and a data register sit inside the block. A small state machine moves values between them and a synchronous memory port over several clock cycles.

There are three operations:

- **Load:** copies a memory word into a register.
- **Store:** copies a register into memory.
- **Memory-to-memory add:** reads two words, each through its own pointer register, and adds them. The sum goes back to the location that the first pointer names. The add reuses the load path twice, adds in a register step, and then leaves through the store path.

A caller raises `start_i` for one cycle with an operation code and three register indices. It then waits for `busy_o` to fall. The memory side holds any access phase until `mem_ready_i` is seen high.

Top module: `rind_seq`

## Requirements
- R1: After reset, `busy_o`, `mem_rd_o` and `mem_wr_o` are low, and every register of the file holds zero.
- R2: Op code 2'b00 (load) writes mem[reg[rs]] into reg[rd]. The address on `mem_addr_o` equals reg[rs] exactly, with no displacement.
- R3: A load passes through three phases (address capture, memory read, write-back). With memory ready, `busy_o` is high for exactly 3 cycles and `mem_rd_o` for exactly 1 cycle. `mem_rd_o` is never high outside the read phase.
- R4: A load whose rd equals rs takes its address from the old pointer value, and the loaded word then replaces that register.
- R5: Op code 2'b01 (store) writes reg[rd] to mem[reg[rs]]. `mem_wr_o` stays high until one accepted (ready) cycle and is never high together with `mem_rd_o`. With memory ready, `busy_o` is high for 2 cycles.
- R6: Op code 2'b10 (add) writes (mem[reg[rs]] + mem[reg[rt]]) mod 2^32 to mem[reg[rs]], and changes no register. With memory ready, it is busy for 6 cycles.
- R7: While `mem_ready_i` is low, the current access phase holds its strobe, `mem_addr_o` and `mem_wdata_o`. Each wait cycle adds one cycle of busy.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The running operation keeps its latched indices, and no second operation follows.
- R9: Register 0 is an ordinary register. It can be loaded and used as a pointer.
- R10: Op code 2'b11 is reserved. A start carrying it leaves the block idle and produces no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request pulse, sampled while idle |
| op_i | input | 2 | Operation code: 00 load, 01 store, 10 add, 11 reserved |
| rd_idx_i | input | 5 | Load destination or store source register |
| rs_idx_i | input | 5 | First pointer register |
| rt_idx_i | input | 5 | Second pointer register (add only) |
| busy_o | output | 1 | High from accepted start until the operation completes |
| mem_addr_o | output | 32 | Memory address, driven from the address register |
| mem_wdata_o | output | 32 | Memory write data, driven from the data register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts or completes the current access |

## Verification
The bench sets the case where the destination is also the pointer. A design that read the pointer after write-back would fetch from the wrong location. It stalls the memory for several cycles on reads and on writes. A design that advanced without ready would capture stale data, or commit a store more than once or not at all.

The add is run with a carry out of bit 31 and with both pointers naming the same word. A design that kept the wrong temporary or skipped a read would store a wrong sum. A start raised in the middle of an operation must neither redirect nor queue work, so a block that re-latched its indices would corrupt the running load or issue a stray store. The reserved op code and pointer register 0 are exercised to catch a decoder that treats them specially.

// File: rtl/rind_pkg.sv
package rind_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ADD   = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_READ,
    ST_WB,
    ST_ADDR2,
    ST_READ2,
    ST_SUM,
    ST_WRITE
  } st_e;

endpackage

// File: rtl/rind_regfile.sv
module rind_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [IW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o,
  input  logic          we_i,
  input  logic [IW-1:0] w_idx_i,
  input  logic [DW-1:0] w_data_i
);

  logic [DW-1:0] rd_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    logic          en;
    assign en = we_i && (w_idx_i == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= w_data_i;
    end
    assign rd_arr[g] = q;
  end

  assign ra_data_o = rd_arr[ra_idx_i];
  assign rb_data_o = rd_arr[rb_idx_i];

endmodule

// File: rtl/rind_ctrl.sv
module rind_ctrl
  import rind_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [IW-1:0] rd_i,
  input  logic [IW-1:0] rs_i,
  input  logic [IW-1:0] rt_i,
  input  logic          mem_ready_i,
  output logic          busy_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          mar_ld_o,
  output logic [IW-1:0] ptr_idx_o,
  output logic [IW-1:0] src_idx_o,
  output logic          mdr_mem_ld_o,
  output logic          mdr_reg_ld_o,
  output logic          mdr_sum_ld_o,
  output logic          tmp_ld_o,
  output logic          rf_we_o,
  output logic [IW-1:0] rf_widx_o
);

  st_e           state_q, state_d;
  op_e           op_q;
  logic [IW-1:0] rd_q, rs_q, rt_q;
  logic          accept;

  assign accept = (state_q == ST_IDLE) && start_i && (op_i != 2'(OP_RSVD));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ADDR;
      ST_ADDR:  state_d = (op_q == OP_STORE) ? ST_WRITE : ST_READ;
      ST_READ:  if (mem_ready_i) state_d = (op_q == OP_ADD) ? ST_ADDR2 : ST_WB;
      ST_WB:    state_d = ST_IDLE;
      ST_ADDR2: state_d = ST_READ2;
      ST_READ2: if (mem_ready_i) state_d = ST_SUM;
      ST_SUM:   state_d = ST_WRITE;
      ST_WRITE: if (mem_ready_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_LOAD;
      rd_q <= '0;
      rs_q <= '0;
      rt_q <= '0;
    end else if (accept) begin
      op_q <= op_e'(op_i);
      rd_q <= rd_i;
      rs_q <= rs_i;
      rt_q <= rt_i;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign mem_rd_o     = (state_q == ST_READ) || (state_q == ST_READ2);
  assign mem_wr_o     = (state_q == ST_WRITE);
  assign mar_ld_o     = (state_q == ST_ADDR) || (state_q == ST_ADDR2) || (state_q == ST_SUM);
  assign ptr_idx_o    = (state_q == ST_ADDR2) ? rt_q : rs_q;
  assign src_idx_o    = rd_q;
  assign mdr_reg_ld_o = (state_q == ST_ADDR) && (op_q == OP_STORE);
  assign mdr_mem_ld_o = (state_q == ST_READ) && mem_ready_i;
  assign tmp_ld_o     = (state_q == ST_READ2) && mem_ready_i;
  assign mdr_sum_ld_o = (state_q == ST_SUM);
  assign rf_we_o      = (state_q == ST_WB);
  assign rf_widx_o    = rd_q;

  assert_no_dual_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(op_q) && $stable(rd_q) && $stable(rs_q) && $stable(rt_q)));

  assert_wb_only_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (op_q == OP_LOAD));

  assert_rsvd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && (op_i == 2'b11)) |=> !busy_o);

endmodule

// File: rtl/rind_seq.sv
module rind_seq
  import rind_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [IW-1:0] rd_idx_i,
  input  logic [IW-1:0] rs_idx_i,
  input  logic [IW-1:0] rt_idx_i,
  output logic          busy_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i
);

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          mar_ld, mdr_mem_ld, mdr_reg_ld, mdr_sum_ld, tmp_ld, rf_we;
  logic [IW-1:0] ptr_idx, src_idx, rf_widx;
  logic [DW-1:0] ptr_data, src_data;
  logic [DW-1:0] mar_q, mdr_q, mdr_d, tmp_q;
  logic          mdr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rind_ctrl #(.IW(IW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start_i      (start_i),
    .op_i         (op_i),
    .rd_i         (rd_idx_i),
    .rs_i         (rs_idx_i),
    .rt_i         (rt_idx_i),
    .mem_ready_i  (mem_ready_i),
    .busy_o       (busy_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .mar_ld_o     (mar_ld),
    .ptr_idx_o    (ptr_idx),
    .src_idx_o    (src_idx),
    .mdr_mem_ld_o (mdr_mem_ld),
    .mdr_reg_ld_o (mdr_reg_ld),
    .mdr_sum_ld_o (mdr_sum_ld),
    .tmp_ld_o     (tmp_ld),
    .rf_we_o      (rf_we),
    .rf_widx_o    (rf_widx)
  );

  rind_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ra_idx_i  (ptr_idx),
    .ra_data_o (ptr_data),
    .rb_idx_i  (src_idx),
    .rb_data_o (src_data),
    .we_i      (rf_we),
    .w_idx_i   (rf_widx),
    .w_data_i  (mdr_q)
  );

  always_comb begin
    mdr_en = mdr_mem_ld || mdr_reg_ld || mdr_sum_ld;
    if (mdr_mem_ld)      mdr_d = mem_rdata_i;
    else if (mdr_reg_ld) mdr_d = src_data;
    else                 mdr_d = mdr_q + tmp_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mar_q <= '0;
      mdr_q <= '0;
      tmp_q <= '0;
    end else begin
      if (mar_ld) mar_q <= ptr_data;
      if (mdr_en) mdr_q <= mdr_d;
      if (tmp_ld) tmp_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_rd_o && !mem_ready_i) |=> (mem_rd_o && $stable(mem_addr_o)));

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_wr_o && !mem_ready_i) |=> (mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_read_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_rd_o |-> (busy_o && !rf_we));

  assert_one_commit_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_wr_o && mem_ready_i) |=> !mem_wr_o);

endmodule

// File: tb/rind_seq_tb.sv
module rind_seq_tb;

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, AD = 2'b10, RV = 2'b11;

  typedef struct packed {
    logic [4:0]  ptr;
    logic [4:0]  dst;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  wt;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{5'd1,  5'd2,  8'd10,  32'h0000_00A5, 4'd0},
    '{5'd3,  5'd4,  8'd11,  32'hDEAD_BEEF, 4'd1},
    '{5'd5,  5'd6,  8'd20,  32'h1234_5678, 4'd2},
    '{5'd7,  5'd8,  8'd33,  32'hFFFF_FFFF, 4'd0},
    '{5'd9,  5'd10, 8'd128, 32'h8000_0001, 4'd3},
    '{5'd30, 5'd29, 8'd199, 32'h0F0F_0F0F, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [4:0]  rd = '0, rs = '0, rt = '0;
  logic        busy, mem_rd, mem_wr, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_addr = '0;
  logic [31:0] poke_data = '0;
  logic        clr_en = 1'b0;
  logic [3:0]  wait_cfg = '0;
  logic [3:0]  wait_left = '0;
  int          rd_cyc = 0, wr_cyc = 0, wr_commit = 0;
  logic [31:0] last_addr = '0;

  int checks = 0;
  int errs = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  rind_seq u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .op_i        (op),
    .rd_idx_i    (rd),
    .rs_idx_i    (rs),
    .rt_idx_i    (rt),
    .busy_o      (busy),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .mem_rdata_i (mem_rdata),
    .mem_ready_i (mem_ready)
  );

  assign mem_ready = (wait_left == 4'd0);
  assign mem_rdata = mem[mem_addr[7:0]];

  always_ff @(posedge clk) begin
    if (poke_en) mem[poke_addr] <= poke_data;
    else if (mem_wr && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
    if (clr_en) begin
      wait_left <= wait_cfg;
      rd_cyc    <= 0;
      wr_cyc    <= 0;
      wr_commit <= 0;
    end else begin
      if ((mem_rd || mem_wr) && wait_left != 4'd0) wait_left <= wait_left - 4'd1;
      if (mem_rd) rd_cyc <= rd_cyc + 1;
      if (mem_wr) wr_cyc <= wr_cyc + 1;
      if (mem_wr && mem_ready) wr_commit <= wr_commit + 1;
    end
    if (mem_rd && mem_ready) last_addr <= mem_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] o, input logic [4:0] d, input logic [4:0] s,
                       input logic [4:0] t, input logic [3:0] w, input int exp_busy,
                       input string tag, input bit intrude);
    int n = 0;
    @(negedge clk);
    clr_en = 1'b1; wait_cfg = w;
    start = 1'b1; op = o; rd = d; rs = s; rt = t;
    @(negedge clk);
    clr_en = 1'b0; start = 1'b0;
    while (busy && n < 200) begin
      n++;
      if (intrude && n == 2) begin
        start = 1'b1; op = ST; rd = 5'd14; rs = 5'd13;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk({tag, " busy cycles"}, 32'(n), 32'(exp_busy));
  endtask

  task automatic setreg(input logic [4:0] r, input logic [31:0] v);
    poke(8'd0, v);
    do_op(LD, r, 5'd0, 5'd0, 4'd0, 3, "R2 setup", 1'b0);
  endtask

  task automatic readreg(input logic [4:0] r, output logic [31:0] v);
    do_op(ST, r, 5'd31, 5'd0, 4'd0, 2, "R5 readback", 1'b0);
    v = mem[200];
  endtask

  initial begin
    #1_000_000;
    if (!fin) begin
      errs++;
      $display("FAIL watchdog R1..: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs and zeroed register file
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 mem_rd", 32'(mem_rd), 32'd0);
    chk("R1 mem_wr", 32'(mem_wr), 32'd0);
    poke(8'd0, 32'h5555_5555);
    do_op(ST, 5'd5, 5'd31, 5'd0, 4'd0, 2, "R1 store", 1'b0);
    chk("R1 reg5 zero at mem[0]", mem[0], 32'd0);

    setreg(5'd31, 32'd200);

    // R2, R3, R7: table walk of loads
    foreach (VEC[i]) begin
      setreg(VEC[i].ptr, 32'(VEC[i].addr));
      poke(VEC[i].addr, VEC[i].data);
      do_op(LD, VEC[i].dst, VEC[i].ptr, 5'd0, VEC[i].wt, 3 + int'(VEC[i].wt), "R3 R7 load", 1'b0);
      chk("R3 read strobe cycles", 32'(rd_cyc), 32'(VEC[i].wt) + 32'd1);
      chk("R3 no write strobe", 32'(wr_cyc), 32'd0);
      chk("R2 address exact", last_addr, 32'(VEC[i].addr));
      readreg(VEC[i].dst, v);
      chk("R2 loaded value", v, VEC[i].data);
    end

    // R4: destination equals pointer
    setreg(5'd12, 32'd50);
    poke(8'd50, 32'h0000_1234);
    do_op(LD, 5'd12, 5'd12, 5'd0, 4'd0, 3, "R4 load", 1'b0);
    chk("R4 address from old pointer", last_addr, 32'd50);
    readreg(5'd12, v);
    chk("R4 pointer overwritten", v, 32'h0000_1234);

    // R5, R7: store with stalled memory
    setreg(5'd13, 32'd80);
    setreg(5'd14, 32'hCAFE_F00D);
    poke(8'd80, 32'd0);
    do_op(ST, 5'd14, 5'd13, 5'd0, 4'd3, 5, "R5 R7 store", 1'b0);
    chk("R7 write strobe held", 32'(wr_cyc), 32'd4);
    chk("R5 single commit", 32'(wr_commit), 32'd1);
    chk("R5 no read", 32'(rd_cyc), 32'd0);
    chk("R5 stored value", mem[80], 32'hCAFE_F00D);

    // R6: add with carry out and a stall on the first read
    setreg(5'd15, 32'd60);
    setreg(5'd16, 32'd61);
    poke(8'd60, 32'hFFFF_FFF0);
    poke(8'd61, 32'h0000_0025);
    do_op(AD, 5'd0, 5'd15, 5'd16, 4'd2, 8, "R6 add", 1'b0);
    chk("R6 sum", mem[60], 32'h0000_0015);
    chk("R6 read cycles", 32'(rd_cyc), 32'd4);
    chk("R6 one write", 32'(wr_commit), 32'd1);
    chk("R6 source untouched", mem[61], 32'h0000_0025);
    readreg(5'd15, v);
    chk("R6 reg15 unchanged", v, 32'd60);
    readreg(5'd16, v);
    chk("R6 reg16 unchanged", v, 32'd61);
    poke(8'd60, 32'd5);
    do_op(AD, 5'd0, 5'd15, 5'd15, 4'd0, 6, "R6 add same ptr", 1'b0);
    chk("R6 doubled", mem[60], 32'd10);

    // R8: start while busy is ignored
    poke(8'd80, 32'd0);
    setreg(5'd17, 32'd90);
    poke(8'd90, 32'h0000_0099);
    do_op(LD, 5'd18, 5'd17, 5'd0, 4'd4, 7, "R8 load", 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 idle after", 32'(busy), 32'd0);
    chk("R8 no stray store", mem[80], 32'd0);
    chk("R8 no write strobe", 32'(wr_cyc), 32'd0);
    readreg(5'd18, v);
    chk("R8 running op kept rd", v, 32'h0000_0099);

    // R10: reserved code
    @(negedge clk);
    clr_en = 1'b1; start = 1'b1; op = RV; rd = 5'd1; rs = 5'd1; rt = 5'd1;
    @(negedge clk);
    clr_en = 1'b0; start = 1'b0;
    chk("R10 stays idle", 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 no access", 32'(rd_cyc + wr_cyc), 32'd0);

    // R9: register 0 as loaded pointer
    poke(8'd0, 32'd90);
    do_op(LD, 5'd0, 5'd0, 5'd0, 4'd0, 3, "R9 load r0", 1'b0);
    poke(8'd90, 32'h0000_0077);
    do_op(LD, 5'd1, 5'd0, 5'd0, 4'd0, 3, "R9 via r0", 1'b0);
    chk("R9 address from r0", last_addr, 32'd90);
    readreg(5'd1, v);
    chk("R9 value", v, 32'h0000_0077);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule